// File: doc/BRIEF.md
# Initializing Store Match Table

This block is a small fully-associative table of physical cache-block addresses. A separate range tracker marks these addresses as belonging to stores that will write uninitialized heap memory. The tracker writes an entry through the insert port. The insert port takes the physical tag from the translation unit and the untranslated page offset of the store.

The query port sees every store that missed all cache levels under a write-allocate policy and is about to fetch from memory. The lookup matches on the cache-block address only. The block holding an initializing store carries only invalid data, so fetching it is wasted bandwidth.

When a query hits, the table acts one cycle later:
- it pulses a cancel, tagged with the request identifier, toward the outgoing memory request queue;
- it issues a command to install that whole block filled with zeros into the write-allocating cache;
- it drops the entry.

A query that misses leaves the memory fetch untouched. When every entry is occupied, a new insert replaces the entry that has lived longest.

Top module: `init_store_match`

## Requirements
- R1: After reset, every entry is empty: `full_o`, `cancel_o` and `install_o` are 0, and any query misses.
- R2: A query with `qry_valid_i`=1 whose block matches a held entry makes `cancel_o` and `install_o` 1 in the following cycle only, with `cancel_id_o` equal to the query's `qry_id_i` and `install_blk_o` equal to the query address bits [ADDR_W-1:BLK_OFF_W].
- R3: Matching ignores the low BLK_OFF_W address bits (6 by default, a 64-byte block) of both the inserted and the queried address.
- R4: The inserted physical address is `{ins_ptag_i, ins_offset_i}`, with the tag in the upper bits; a query that differs in any tag bit misses.
- R5: A hit consumes its entry, so a repeated query to the same block misses.
- R6: A query whose block is not held produces no cancel and no install in the following cycle.
- R7: `full_o` is 1 exactly when all NUM_ENTRIES (16) entries are held. An insert made while full, with no entry freed in that cycle, replaces the oldest surviving inserted entry.
- R8: If an insert and a query name the same block in the same cycle, the query hits and the entry is not kept.
- R9: Inserting a block that is already held creates no second entry.
- R10: If the table is full and a query hits a held entry in the same cycle as an insert, the new entry takes the freed place and no other entry is evicted.
- R11: Inputs with `qry_valid_i`=0 cause no response and remove nothing; inputs with `ins_valid_i`=0 store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert strobe from the range tracker |
| ins_ptag_i | input | PTAG_W | Physical tag of the initializing store |
| ins_offset_i | input | PAGE_OFF_W | Untranslated page offset of the store |
| qry_valid_i | input | 1 | Store-miss lookup strobe |
| qry_addr_i | input | PTAG_W+PAGE_OFF_W | Physical address of the store miss |
| qry_id_i | input | ID_W | Identifier of the pending memory request |
| cancel_o | output | 1 | Pulse: drop the identified memory request |
| cancel_id_o | output | ID_W | Identifier of the request to drop |
| install_o | output | 1 | Pulse: install a zero-filled block |
| install_blk_o | output | PTAG_W+PAGE_OFF_W-BLK_OFF_W | Block address to install |
| full_o | output | 1 | All entries occupied |

## Verification
The assertions check four things on every cycle:
- a response only ever follows a valid query;
- the cancel identifier and the install block always echo the query of the previous cycle;
- at most one held entry ever matches a lookup, which keeps duplicate inserts out;
- the full flag falls only on a cycle that also produces a hit.

Which entry an eviction picks, and that a hit really consumes its entry, show up only over several operations. The same holds for the same-cycle insert and lookup and for the reuse of a freed place while full. The directed scenarios cover these cases by sequences of inserts and queries.

// File: rtl/ismt_pkg.sv
package ismt_pkg;
  localparam int unsigned DEF_ENTRIES    = 16;
  localparam int unsigned DEF_PTAG_W     = 28;
  localparam int unsigned DEF_PAGE_OFF_W = 12;
  localparam int unsigned DEF_BLK_OFF_W  = 6;
  localparam int unsigned DEF_ID_W       = 5;

  typedef enum logic [1:0] {
    ALLOC_FREE,
    ALLOC_REUSE,
    ALLOC_EVICT
  } alloc_src_e;
endpackage

// File: rtl/ismt_entry.sv
module ismt_entry #(
  parameter int unsigned BLK_W = 34,
  parameter int unsigned AGE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic             clr_i,
  input  logic             age_inc_i,
  input  logic             del_en_i,
  input  logic [AGE_W-1:0] del_age_i,
  input  logic [BLK_W-1:0] qry_blk_i,
  input  logic [BLK_W-1:0] ins_blk_i,
  output logic             valid_o,
  output logic [AGE_W-1:0] age_o,
  output logic             qry_hit_o,
  output logic             ins_hit_o
);
  logic             valid_q;
  logic [BLK_W-1:0] blk_q;
  logic [AGE_W-1:0] age_q, age_nxt;
  logic             age_dec;

  // age = number of held entries inserted after this one
  assign age_dec = del_en_i && (age_q > del_age_i);
  assign age_nxt = age_q + AGE_W'(age_inc_i) - AGE_W'(age_dec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
      age_q   <= '0;
    end else if (wr_en_i) begin
      valid_q <= 1'b1;
      blk_q   <= wr_blk_i;
      age_q   <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      age_q   <= '0;
    end else if (valid_q) begin
      age_q   <= age_nxt;
    end
  end

  assign valid_o   = valid_q;
  assign age_o     = age_q;
  assign qry_hit_o = valid_q && (blk_q == qry_blk_i);
  assign ins_hit_o = valid_q && (blk_q == ins_blk_i);
endmodule

// File: rtl/ismt_alloc.sv
module ismt_alloc
  import ismt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned IDX_W       = 4
) (
  input  logic [NUM_ENTRIES-1:0]       valid_i,
  input  logic [NUM_ENTRIES*IDX_W-1:0] age_i,
  input  logic                         del_en_i,
  input  logic [IDX_W-1:0]             del_idx_i,
  output logic [IDX_W-1:0]             tgt_idx_o,
  output logic                         full_o
);
  localparam logic [IDX_W-1:0] OLDEST_AGE = IDX_W'(NUM_ENTRIES - 1);

  logic             free_found;
  logic [IDX_W-1:0] free_idx, oldest_idx;
  alloc_src_e       src;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (valid_i[i] && age_i[i*IDX_W +: IDX_W] == OLDEST_AGE) oldest_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (free_found)    src = ALLOC_FREE;
    else if (del_en_i) src = ALLOC_REUSE;
    else               src = ALLOC_EVICT;
    unique case (src)
      ALLOC_FREE:  tgt_idx_o = free_idx;
      ALLOC_REUSE: tgt_idx_o = del_idx_i;
      default:     tgt_idx_o = oldest_idx;
    endcase
  end

  assign full_o = &valid_i;
endmodule

// File: rtl/ismt_resp.sv
module ismt_resp #(
  parameter int unsigned ID_W  = 5,
  parameter int unsigned BLK_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             cancel_o,
  output logic [ID_W-1:0]  cancel_id_o,
  output logic             install_o,
  output logic [BLK_W-1:0] install_blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cancel_o      <= 1'b0;
      install_o     <= 1'b0;
      cancel_id_o   <= '0;
      install_blk_o <= '0;
    end else begin
      cancel_o      <= hit_i;
      install_o     <= hit_i;
      cancel_id_o   <= hit_i ? id_i  : '0;
      install_blk_o <= hit_i ? blk_i : '0;
    end
  end
endmodule

// File: rtl/init_store_match.sv
module init_store_match
  import ismt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = DEF_ENTRIES,
  parameter int unsigned PTAG_W      = DEF_PTAG_W,
  parameter int unsigned PAGE_OFF_W  = DEF_PAGE_OFF_W,
  parameter int unsigned BLK_OFF_W   = DEF_BLK_OFF_W,
  parameter int unsigned ID_W        = DEF_ID_W,
  localparam int unsigned ADDR_W     = PTAG_W + PAGE_OFF_W,
  localparam int unsigned BLK_W      = ADDR_W - BLK_OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ins_valid_i,
  input  logic [PTAG_W-1:0]     ins_ptag_i,
  input  logic [PAGE_OFF_W-1:0] ins_offset_i,
  input  logic                  qry_valid_i,
  input  logic [ADDR_W-1:0]     qry_addr_i,
  input  logic [ID_W-1:0]       qry_id_i,
  output logic                  cancel_o,
  output logic [ID_W-1:0]       cancel_id_o,
  output logic                  install_o,
  output logic [BLK_W-1:0]      install_blk_o,
  output logic                  full_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  logic [BLK_W-1:0] ins_blk, qry_blk;
  logic             unused_low_bits;

  logic [NUM_ENTRIES-1:0]       valid_vec, qry_hit_vec, ins_hit_vec, wr_en_vec, clr_vec;
  logic [NUM_ENTRIES*IDX_W-1:0] age_flat;
  logic [IDX_W-1:0]             hit_idx, tgt_idx, del_age;
  logic                         stored_hit, bypass_hit, ins_dup, ins_store, resp_hit;

  assign ins_blk = {ins_ptag_i, ins_offset_i[PAGE_OFF_W-1:BLK_OFF_W]};
  assign qry_blk = qry_addr_i[ADDR_W-1:BLK_OFF_W];
  assign unused_low_bits = ^{qry_addr_i[BLK_OFF_W-1:0], ins_offset_i[BLK_OFF_W-1:0]};

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (qry_hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign stored_hit = qry_valid_i && (|qry_hit_vec);
  assign bypass_hit = qry_valid_i && ins_valid_i && (ins_blk == qry_blk);
  assign ins_dup    = |ins_hit_vec;
  // same-block insert is consumed by the concurrent query
  assign ins_store  = ins_valid_i && !ins_dup && !bypass_hit;
  assign resp_hit   = stored_hit || bypass_hit;
  assign del_age    = age_flat[hit_idx*IDX_W +: IDX_W];

  ismt_alloc #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_alloc (
    .valid_i  (valid_vec),
    .age_i    (age_flat),
    .del_en_i (stored_hit),
    .del_idx_i(hit_idx),
    .tgt_idx_o(tgt_idx),
    .full_o   (full_o)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    assign wr_en_vec[g] = ins_store && (tgt_idx == IDX_W'(g));
    assign clr_vec[g]   = stored_hit && (hit_idx == IDX_W'(g)) && !wr_en_vec[g];

    ismt_entry #(
      .BLK_W(BLK_W),
      .AGE_W(IDX_W)
    ) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_vec[g]),
      .wr_blk_i (ins_blk),
      .clr_i    (clr_vec[g]),
      .age_inc_i(ins_store),
      .del_en_i (stored_hit),
      .del_age_i(del_age),
      .qry_blk_i(qry_blk),
      .ins_blk_i(ins_blk),
      .valid_o  (valid_vec[g]),
      .age_o    (age_flat[g*IDX_W +: IDX_W]),
      .qry_hit_o(qry_hit_vec[g]),
      .ins_hit_o(ins_hit_vec[g])
    );
  end

  ismt_resp #(
    .ID_W (ID_W),
    .BLK_W(BLK_W)
  ) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (resp_hit),
    .id_i         (qry_id_i),
    .blk_i        (qry_blk),
    .cancel_o     (cancel_o),
    .cancel_id_o  (cancel_id_o),
    .install_o    (install_o),
    .install_blk_o(install_blk_o)
  );
endmodule

// File: rtl/ismt_checker.sv
module ismt_checker #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned ID_W        = 5,
  parameter int unsigned BLK_W       = 34
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   qry_valid_i,
  input logic [BLK_W-1:0]       qry_blk_i,
  input logic [ID_W-1:0]        qry_id_i,
  input logic                   cancel_o,
  input logic [ID_W-1:0]        cancel_id_o,
  input logic                   install_o,
  input logic [BLK_W-1:0]       install_blk_o,
  input logic                   full_o,
  input logic [NUM_ENTRIES-1:0] qry_hit_vec_i
);
  p_resp_needs_query_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_o || install_o) |-> $past(qry_valid_i));

  p_cancel_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> (cancel_id_o == $past(qry_id_i)));

  p_install_blk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    install_o |-> (install_blk_o == $past(qry_blk_i)));

  p_unique_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(qry_hit_vec_i));

  p_full_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> cancel_o);
endmodule

bind init_store_match ismt_checker #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ID_W       (ID_W),
  .BLK_W      (BLK_W)
) u_ismt_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .qry_valid_i  (qry_valid_i),
  .qry_blk_i    (qry_addr_i[ADDR_W-1:BLK_OFF_W]),
  .qry_id_i     (qry_id_i),
  .cancel_o     (cancel_o),
  .cancel_id_o  (cancel_id_o),
  .install_o    (install_o),
  .install_blk_o(install_blk_o),
  .full_o       (full_o),
  .qry_hit_vec_i(qry_hit_vec)
);

// File: tb/init_store_match_test.sv
module init_store_match_test;
  localparam int CLK_PERIOD = 10;
  localparam int PTAG_W = 28;
  localparam int OFF_W  = 12;
  localparam int ADDR_W = 40;
  localparam int BLK_W  = 34;
  localparam int ID_W   = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ins_valid;
  logic [PTAG_W-1:0] ins_ptag;
  logic [OFF_W-1:0]  ins_off;
  logic              qry_valid;
  logic [ADDR_W-1:0] qry_addr;
  logic [ID_W-1:0]   qry_id;
  logic              cancel, install, full;
  logic [ID_W-1:0]   cancel_id;
  logic [BLK_W-1:0]  install_blk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_store_match uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ins_valid_i  (ins_valid),
    .ins_ptag_i   (ins_ptag),
    .ins_offset_i (ins_off),
    .qry_valid_i  (qry_valid),
    .qry_addr_i   (qry_addr),
    .qry_id_i     (qry_id),
    .cancel_o     (cancel),
    .cancel_id_o  (cancel_id),
    .install_o    (install),
    .install_blk_o(install_blk),
    .full_o       (full)
  );

  function automatic logic [ADDR_W-1:0] mk(input logic [BLK_W-1:0] blk, input logic [5:0] lo);
    return {blk, lo};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic iv, input logic [ADDR_W-1:0] ia,
                    input logic qv, input logic [ADDR_W-1:0] qa, input logic [ID_W-1:0] qid);
    @(negedge clk);
    ins_valid = iv; ins_ptag = ia[ADDR_W-1:OFF_W]; ins_off = ia[OFF_W-1:0];
    qry_valid = qv; qry_addr = qa; qry_id = qid;
    @(posedge clk);
    #1;
    ins_valid = 1'b0; qry_valid = 1'b0;
  endtask

  task automatic insert(input logic [ADDR_W-1:0] a);
    op(1'b1, a, 1'b0, '0, '0);
  endtask

  task automatic expect_hit(input string tag, input logic [ADDR_W-1:0] qa, input logic [ID_W-1:0] id);
    op(1'b0, '0, 1'b1, qa, id);
    chk({tag, " cancel"}, 64'(cancel), 64'd1);
    chk({tag, " cancel_id"}, 64'(cancel_id), 64'(id));
    chk({tag, " install"}, 64'(install), 64'd1);
    chk({tag, " install_blk"}, 64'(install_blk), 64'(qa[ADDR_W-1:6]));
  endtask

  task automatic expect_miss(input string tag, input logic [ADDR_W-1:0] qa);
    op(1'b0, '0, 1'b1, qa, 5'd9);
    chk({tag, " cancel"}, 64'(cancel), 64'd0);
    chk({tag, " install"}, 64'(install), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 full after reset", 64'(full), 64'd0);
    chk("R1 cancel after reset", 64'(cancel), 64'd0);
    chk("R1 install after reset", 64'(install), 64'd0);
    expect_miss("R1 empty table", mk(34'h123, 6'h0));
  endtask

  task automatic t_basic();
    insert(mk(34'h1000, 6'h10));
    expect_hit("R2 R3 hit other low bits", mk(34'h1000, 6'h3F), 5'd7);
    op(1'b0, '0, 1'b0, '0, '0);
    chk("R2 cancel is one pulse", 64'(cancel), 64'd0);
    chk("R2 install is one pulse", 64'(install), 64'd0);
    expect_miss("R5 consumed entry", mk(34'h1000, 6'h10));
    // R4: tag in upper bits, offset below
    op(1'b1, {28'h0ABCDEF, 12'h5C0}, 1'b0, '0, '0);
    expect_miss("R4 tag bit differs", {28'h0ABCDEE, 12'h5C0});
    expect_hit("R4 tag and offset joined", {28'h0ABCDEF, 12'h5C4}, 5'd30);
  endtask

  task automatic t_miss_idle();
    insert(mk(34'h1100, 6'h0));
    expect_miss("R6 other block", mk(34'h1101, 6'h0));
    op(1'b0, '0, 1'b0, mk(34'h1100, 6'h0), 5'd3);
    chk("R11 invalid query no cancel", 64'(cancel), 64'd0);
    expect_hit("R11 entry survived idle query", mk(34'h1100, 6'h8), 5'd4);
    op(1'b0, mk(34'h1200, 6'h0), 1'b0, '0, '0);
    expect_miss("R11 invalid insert stores nothing", mk(34'h1200, 6'h0));
  endtask

  task automatic t_same_cycle();
    op(1'b1, mk(34'h1300, 6'h1), 1'b1, mk(34'h1300, 6'h2), 5'd11);
    chk("R8 same cycle hit cancel", 64'(cancel), 64'd1);
    chk("R8 same cycle install_blk", 64'(install_blk), 64'h1300);
    expect_miss("R8 entry not kept", mk(34'h1300, 6'h0));
  endtask

  task automatic t_dup();
    insert(mk(34'h1400, 6'h0));
    insert(mk(34'h1400, 6'h20));
    expect_hit("R9 dup first query", mk(34'h1400, 6'h0), 5'd1);
    expect_miss("R9 no second copy", mk(34'h1400, 6'h0));
  endtask

  task automatic t_full();
    for (int i = 0; i < 15; i++) insert(mk(34'h2000 + 34'(i), 6'h0));
    chk("R7 not full at 15", 64'(full), 64'd0);
    insert(mk(34'h2003, 6'h11));
    chk("R9 dup does not fill", 64'(full), 64'd0);
    insert(mk(34'h200F, 6'h0));
    chk("R7 full at 16", 64'(full), 64'd1);
    insert(mk(34'h2010, 6'h0));
    chk("R7 still full after evict", 64'(full), 64'd1);
    expect_miss("R7 oldest evicted", mk(34'h2000, 6'h0));
    op(1'b1, mk(34'h2020, 6'h0), 1'b1, mk(34'h2005, 6'h0), 5'd3);
    chk("R10 hit while inserting", 64'(cancel), 64'd1);
    chk("R10 freed place reused", 64'(full), 64'd1);
    expect_hit("R10 oldest kept", mk(34'h2001, 6'h0), 5'd2);
    chk("R7 full drops after hit", 64'(full), 64'd0);
    expect_hit("R10 new entry held", mk(34'h2020, 6'h0), 5'd6);
    expect_hit("R7 newest survivor", mk(34'h2010, 6'h0), 5'd8);
  endtask

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_ptag = '0; ins_off = '0;
    qry_valid = 1'b0; qry_addr = '0; qry_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_miss_idle();
    t_same_cycle();
    t_dup();
    t_full();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule